// File: doc/BRIEF.md
# Color-Expansion Source Byte Generator

This block feeds a 2D block-transfer engine with one source byte per step. The engine runs in color-expansion mode. Each monochrome mask bit chooses between a 32-bit foreground color and a 32-bit background color. The block then picks the byte of that color which belongs to the current destination byte. Pixels may be 8, 16, 24 or 32 bits wide, and at 24 bits the byte lanes repeat in a cycle of three rather than a power of two.

The mask bits come from one of two places. The first is a pattern row byte, indexed by the horizontal byte counter. The second is host data held in an internal shift register, read most significant bit first from either bit 7 (byte granularity) or bit 31 (word granularity). The shift register moves on by one bit only on the last byte of a pixel, and when it does the block reports that one host bit was used. In pattern mode a solid-fill control forces the foreground color whatever the mask says.

Memory access, raster operations and address stepping belong to the surrounding engine. The results are registered and come out one cycle after each step strobe.

Top module: `cx_src_gen`

## Requirements
- R1: After reset, `src_byte_o`, `mask_o`, `src_valid_o` and `host_take_o` are 0 and the host shift register holds 0. A host step taken before any load therefore sees a mask bit of 0.
- R2: A result appears on the outputs on the clock edge of the step. `src_valid_o` is 1 in the cycle after a step and 0 after a cycle with no step. After a cycle with no step, `src_byte_o` and `mask_o` keep their earlier values.
- R3: A mask bit of 1 selects `fg_i` and a mask bit of 0 selects `bg_i`, unless R11 applies.
- R4: With `pix_fmt_i` = 0 (8 bits per pixel), the output is color bits 7:0 for every address.
- R5: With `pix_fmt_i` = 1 (16 bits per pixel), an even `dst_addr_i` gives color bits 7:0 and an odd one gives bits 15:8.
- R6: With `pix_fmt_i` = 2 (24 bits per pixel), `dst_addr_i` modulo 3 equal to 0, 1 or 2 gives color bits 7:0, 15:8 or 23:16.
- R7: With `pix_fmt_i` = 3 (32 bits per pixel), `dst_addr_i[1:0]` selects color byte 0 to 3, with 0 being bits 7:0.
- R8: With `host_src_i` = 0, the mask bit is bit (7 − `x_cnt_i`/N) of `pat_row_i`. N is the number of bytes per pixel (1 to 4), and `x_cnt_i` runs from 0 to 8N−1.
- R9: With `host_src_i` = 1, the mask bit is bit 31 of the host shift register when `wide_word_i` = 1 and bit 7 when `wide_word_i` = 0.
- R10: A host step shifts the host register left by one and pulses `host_take_o` only on the last byte of a pixel. That is every byte at 8 bits, an odd address at 16, an address modulo 3 equal to 2 at 24, and `dst_addr_i[1:0]` = 3 at 32. A pattern step never pulses `host_take_o`.
- R11: With `solid_fill_i` = 1 and `host_src_i` = 0, the output comes from `fg_i` whatever the mask. With `host_src_i` = 1, `solid_fill_i` has no effect.
- R12: `host_load_i` writes `host_word_i` into the shift register. A step in the same cycle uses the newly loaded word.
- R13: `mask_o` always reports the raw mask bit that was picked, including under solid fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Produce one source byte |
| pix_fmt_i | input | 2 | Pixel width code: 0=8, 1=16, 2=24, 3=32 bits |
| host_src_i | input | 1 | 1 = mask from host data, 0 = mask from pattern row |
| wide_word_i | input | 1 | Host mask bit taken from bit 31 (1) or bit 7 (0) |
| solid_fill_i | input | 1 | Force foreground in pattern mode |
| fg_i | input | 32 | Foreground color |
| bg_i | input | 32 | Background color |
| dst_addr_i | input | ADDR_W | Destination byte address (lane select) |
| x_cnt_i | input | XCNT_W | Horizontal byte counter within the pattern row |
| pat_row_i | input | 8 | Pattern row byte |
| host_load_i | input | 1 | Load host word into shift register |
| host_word_i | input | 32 | Host data word |
| src_byte_o | output | 8 | Registered source byte |
| mask_o | output | 1 | Raw mask bit of the last step |
| src_valid_o | output | 1 | Source byte produced by the previous step |
| host_take_o | output | 1 | One host bit was used by the previous step |

## Verification
The bench aims at the 24-bit case. There, a design that reduced the address modulo 4, or divided the counter by a power of two, would output the wrong lane and read the wrong pattern bit from the second pixel on. It also checks host shifting on every byte position of each pixel width. A design that shifted on every byte would let the mask drift through 16-, 24- and 32-bit pixels, and `host_take_o` would show it. Further checks cover solid fill with an all-zero pattern and with host data, a load and a step in the same cycle, and idle cycles with the colors changed underneath. Each of these exposes a design that leaks the mask, takes the stale word, or lets its output drift.

// File: rtl/cx_src_pkg.sv
package cx_src_pkg;

    typedef enum logic [1:0] {
        PIX_8  = 2'd0,
        PIX_16 = 2'd1,
        PIX_24 = 2'd2,
        PIX_32 = 2'd3
    } pix_fmt_e;

    localparam int unsigned HOST_W = 32;

    typedef struct packed {
        logic [7:0]        src;
        logic              mask;
        logic              take;
        logic              vld;
        logic [HOST_W-1:0] sh;
    } cx_state_t;

    // Residue modulo 3, one bit at a time from the top, kept to two bits.
    function automatic logic [1:0] mod3_32(input logic [31:0] v);
        logic [1:0] r;
        logic [2:0] t;
        r = 2'd0;
        for (int i = 31; i >= 0; i--) begin
            t = {r, v[i]};
            r = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/cx_lane_sel.sv
module cx_lane_sel
    import cx_src_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [1:0]        fmt_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [1:0]        lane_o,
    output logic              last_o
);
    logic [1:0] res3;

    always_comb begin
        res3 = mod3_32(32'(addr_i));
        unique case (pix_fmt_e'(fmt_i))
            PIX_8: begin
                lane_o = 2'd0;
                last_o = 1'b1;
            end
            PIX_16: begin
                lane_o = {1'b0, addr_i[0]};
                last_o = addr_i[0];
            end
            PIX_24: begin
                lane_o = res3;
                last_o = (res3 == 2'd2);
            end
            default: begin
                lane_o = addr_i[1:0];
                last_o = (addr_i[1:0] == 2'd3);
            end
        endcase
    end

endmodule

// File: rtl/cx_mask_sel.sv
module cx_mask_sel
    import cx_src_pkg::*;
#(
    parameter int unsigned XCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_i,
    input  logic [1:0]        fmt_i,
    input  logic              host_src_i,
    input  logic              wide_i,
    input  logic              host_b7_i,
    input  logic              host_b31_i,
    input  logic [XCNT_W-1:0] x_cnt_i,
    input  logic [7:0]        pat_i,
    output logic              bit_o
);
    logic [XCNT_W-1:0] pix_idx;
    logic [2:0]        bit_sel;

    always_comb begin
        unique case (pix_fmt_e'(fmt_i))
            PIX_8:   pix_idx = x_cnt_i;
            PIX_16:  pix_idx = x_cnt_i >> 1;
            PIX_24:  pix_idx = x_cnt_i / XCNT_W'(3);
            default: pix_idx = x_cnt_i >> 2;
        endcase
        bit_sel = 3'd7 - pix_idx[2:0];
        if (host_src_i)
            bit_o = wide_i ? host_b31_i : host_b7_i;
        else
            bit_o = pat_i[bit_sel];
    end

    AST_PIXEL_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_i |-> (pix_idx < XCNT_W'(8))); // R8

endmodule

// File: rtl/cx_src_gen.sv
module cx_src_gen
    import cx_src_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned XCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [1:0]        pix_fmt_i,
    input  logic              host_src_i,
    input  logic              wide_word_i,
    input  logic              solid_fill_i,
    input  logic [31:0]       fg_i,
    input  logic [31:0]       bg_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [XCNT_W-1:0] x_cnt_i,
    input  logic [7:0]        pat_row_i,
    input  logic              host_load_i,
    input  logic [31:0]       host_word_i,
    output logic [7:0]        src_byte_o,
    output logic              mask_o,
    output logic              src_valid_o,
    output logic              host_take_o
);
    cx_state_t         st_d, st_q;
    logic [HOST_W-1:0] sh_eff;
    logic [1:0]        lane;
    logic              lane_last;
    logic              mbit;
    logic              use_fg;
    logic [31:0]       color;

    assign sh_eff = host_load_i ? host_word_i : st_q.sh;

    cx_lane_sel #(.ADDR_W(ADDR_W)) u_lane (
        .fmt_i  (pix_fmt_i),
        .addr_i (dst_addr_i),
        .lane_o (lane),
        .last_o (lane_last)
    );

    cx_mask_sel #(.XCNT_W(XCNT_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_i      (step_i && !host_src_i),
        .fmt_i      (pix_fmt_i),
        .host_src_i (host_src_i),
        .wide_i     (wide_word_i),
        .host_b7_i  (sh_eff[7]),
        .host_b31_i (sh_eff[31]),
        .x_cnt_i    (x_cnt_i),
        .pat_i      (pat_row_i),
        .bit_o      (mbit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.take = 1'b0;
        st_d.sh   = sh_eff;
        use_fg    = mbit || (solid_fill_i && !host_src_i);
        color     = use_fg ? fg_i : bg_i;
        if (step_i) begin
            st_d.vld  = 1'b1;
            st_d.mask = mbit;
            st_d.src  = color[{lane, 3'b000} +: 8];
            if (host_src_i && lane_last) begin
                st_d.take = 1'b1;
                st_d.sh   = sh_eff << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_byte_o  = st_q.src;
    assign mask_o      = st_q.mask;
    assign src_valid_o = st_q.vld;
    assign host_take_o = st_q.take;

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> src_valid_o); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!src_valid_o && $stable(src_byte_o) && $stable(mask_o))); // R2
    AST_NO_TAKE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !host_src_i |=> !host_take_o); // R10
    AST_NO_TAKE_MID_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && host_src_i && !lane_last) |=> !host_take_o); // R10
    AST_SOLID_IS_FG: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && solid_fill_i && !host_src_i && pix_fmt_i == 2'd0)
            |=> (src_byte_o == $past(fg_i[7:0]))); // R11
    AST_TAKE_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        host_take_o |-> src_valid_o); // R10

endmodule

// File: tb/sim_cx_src_gen.sv
`timescale 1ns/1ps
module sim_cx_src_gen;
    localparam int ADDR_W = 16;
    localparam int XCNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 0, host = 0, wide = 0, solid = 0, load = 0;
    logic [1:0] fmt = 0;
    logic [31:0] fg = 0, bg = 0, word = 0;
    logic [ADDR_W-1:0] addr = 0;
    logic [XCNT_W-1:0] xc = 0;
    logic [7:0] pat = 0;
    logic [7:0] src_byte;
    logic mask, vld, take;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] m_sh = 0;
    logic [7:0]  m_src = 0;
    logic        m_mask = 0;

    always #10 clk = ~clk;

    cx_src_gen #(.ADDR_W(ADDR_W), .XCNT_W(XCNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step), .pix_fmt_i(fmt),
        .host_src_i(host), .wide_word_i(wide), .solid_fill_i(solid),
        .fg_i(fg), .bg_i(bg), .dst_addr_i(addr), .x_cnt_i(xc),
        .pat_row_i(pat), .host_load_i(load), .host_word_i(word),
        .src_byte_o(src_byte), .mask_o(mask), .src_valid_o(vld),
        .host_take_o(take)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: model the step from the inputs set now, then compare.
    task automatic tick(string tag);
        int n, lane;
        logic [31:0] eff, col;
        logic mb, e_take;
        eff = load ? word : m_sh;
        e_take = 0;
        if (step) begin
            n = int'(fmt) + 1;
            lane = int'(addr) % n;
            if (host) mb = wide ? eff[31] : eff[7];
            else      mb = pat[7 - int'(xc) / n];
            col = (mb || (solid && !host)) ? fg : bg;
            m_src = 8'((col >> (8 * lane)) & 32'hff);
            m_mask = mb;
            if (host && lane == n - 1) begin
                e_take = 1;
                eff = eff << 1;
            end
        end
        m_sh = eff;
        @(posedge clk);
        @(negedge clk);
        check(tag, "src_byte", int'(src_byte), int'(m_src));
        check(tag, "mask", int'(mask), int'(m_mask));
        check(tag, "valid", int'(vld), int'(step));
        check(tag, "take", int'(take), int'(e_take));
        load = 0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        fg = 32'hC3B2A190;
        bg = 32'h4F5E6D7C;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", "src_byte", int'(src_byte), 0);
        check("R1", "mask", int'(mask), 0);
        check("R1", "valid", int'(vld), 0);
        check("R1", "take", int'(take), 0);
        // R1: shift register cleared -> host bit 0, background chosen
        step = 1; host = 1; fmt = 0; addr = 0;
        tick("R1");

        // R4 R8 R3: 8 bits per pixel, pattern mask
        host = 0; pat = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            xc = XCNT_W'(i); addr = ADDR_W'(16'h40 + i);
            tick("R4_R8_R3");
        end
        // R5: 16 bits per pixel
        fmt = 1; pat = 8'h3C;
        for (int i = 0; i < 16; i++) begin
            xc = XCNT_W'(i); addr = ADDR_W'(16'h100 + i);
            tick("R5_R8");
        end
        // R6: 24 bits per pixel, lanes modulo 3 and counter divided by 3
        fmt = 2; pat = 8'h96;
        for (int i = 0; i < 24; i++) begin
            xc = XCNT_W'(i); addr = ADDR_W'(16'h300 + i);
            tick("R6_R8");
        end
        // R7: 32 bits per pixel
        fmt = 3; pat = 8'h5A;
        for (int i = 0; i < 32; i++) begin
            xc = XCNT_W'(i); addr = ADDR_W'(16'h400 + i);
            tick("R7_R8");
        end
        // R2: idle cycles hold output while colors change
        step = 0; fg = 32'h01020304; bg = 32'h0A0B0C0D;
        tick("R2"); tick("R2");
        // R11 R13: solid fill in pattern mode with all-zero pattern
        step = 1; solid = 1; fmt = 2; pat = 8'h00;
        for (int i = 0; i < 6; i++) begin
            xc = XCNT_W'(i); addr = ADDR_W'(16'h600 + i);
            tick("R11_R13");
        end
        // R9 R10: host byte granularity at 8 bits per pixel
        solid = 0; host = 1; wide = 0; fmt = 0;
        load = 1; word = 32'h000000C3;
        step = 0; tick("R12");
        step = 1;
        for (int i = 0; i < 8; i++) begin
            addr = ADDR_W'(i); tick("R9_R10");
        end
        // R11: solid ignored with host data (remaining bits are zero)
        solid = 1;
        for (int i = 0; i < 3; i++) begin
            addr = ADDR_W'(i); tick("R11");
        end
        solid = 0;
        // R10: 16 bits per pixel, byte granularity
        fmt = 1; load = 1; word = 32'h000000A6;
        for (int i = 0; i < 8; i++) begin
            addr = ADDR_W'(16'h21 + i); tick("R10_R12");
        end
        // R9 R10: word granularity at 24 bits per pixel
        fmt = 2; wide = 1; load = 1; word = 32'hB4000001; step = 0;
        tick("R12");
        step = 1;
        for (int i = 0; i < 15; i++) begin
            addr = ADDR_W'(16'h900 + i); tick("R9_R10_R6");
        end
        // R12: load and step in the same cycle, 32 bits per pixel
        fmt = 3; load = 1; word = 32'h80000000;
        for (int i = 0; i < 8; i++) begin
            addr = ADDR_W'(16'h800 + i); tick("R12_R10_R7");
        end
        step = 0; tick("R2");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule